// File: doc/BRIEF.md
# Conversion Start and Auto-Trigger Controller

This block decides the cycle in which an analog-to-digital conversion begins and reports when it ends. Software can start a single conversion by writing the start bit. With auto-triggering enabled, a rising edge on one of several trigger lines, picked by a select field, also starts a conversion. A fixed-length internal timer, advanced by a conversion clock-enable, stands in for the converter. It produces a one-cycle done pulse at the end of every conversion.

A conversion-complete flag is set by every done pulse, and an interrupt request is derived from it. Select code 0 does not refer to an external line. It chooses the completion event itself as the trigger, so once software has started the first conversion, the converter restarts on every done pulse (free-running). A trigger edge is only honoured while the converter is idle, and edges that arrive during a conversion are dropped rather than held for later. The enable input overrides all of this: while it is low nothing starts, and a running conversion is abandoned.

All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake. `start_wr` and `flag_clr_wr` are one-cycle write strobes of a one into the start bit and into the flag.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `flag`, `irq` and `start_pulse` are all 0.
- R2: With `en` high and the converter idle, a cycle with `start_wr` high drives `start_pulse` high in that same cycle, and `busy` reads 1 from the next cycle on.
- R3: A conversion ends with `done` high in the cycle that carries the 13th `conv_tick` after the start cycle. Cycles without `conv_tick` do not advance it. `busy` drops to 0 in the cycle after `done` unless a free-running restart occurs.
- R4: With `auto_en` high and `src_sel` = k (1..7), a 0-to-1 change of `trig_in[k]` while idle starts a conversion in the cycle it is first seen high. Edges on unselected lines, or any edge while `auto_en` is low, start nothing.
- R5: A trigger edge that arrives while `busy` is 1 is dropped and is not replayed later. A trigger line held high starts only one conversion; it must return low before it can start another.
- R6: With `auto_en` high and `src_sel` = 0, every `done` is accompanied by `start_pulse` in the same cycle, and `busy` stays 1, whether or not the flag is cleared. The first conversion still needs `start_wr`, and `trig_in[0]` has no effect.
- R7: `flag` becomes 1 in the cycle after `done` even when `irq_en` is 0. A `flag_clr_wr` strobe clears it in the next cycle, unless `done` is high in that same cycle, in which case `flag` stays 1.
- R8: `irq` is 1 exactly when both `flag` and `irq_en` are 1.
- R9: While `en` is 0, `start_pulse` stays 0. One cycle after `en` falls, `busy` is 0, and the abandoned conversion never produces `done`.
- R10: A `start_wr` strobe during a conversion gives no `start_pulse`, and it neither restarts nor lengthens the running conversion.
- R11: A `start_wr` strobe starts a single conversion even while `auto_en` is high and the selected line shows no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable; low aborts and blocks starts |
| auto_en | input | 1 | Auto-trigger enable |
| src_sel | input | 3 | Trigger select; 0 = completion event (free-running) |
| trig_in | input | 8 | External trigger lines; bit 0 unused |
| start_wr | input | 1 | Strobe: write one to the start bit |
| flag_clr_wr | input | 1 | Strobe: write one to the flag (clears it) |
| irq_en | input | 1 | Interrupt enable |
| conv_tick | input | 1 | Conversion clock enable |
| start_pulse | output | 1 | High in the cycle a conversion is launched |
| busy | output | 1 | Read-back of the start bit: 1 while converting |
| done | output | 1 | High in the last cycle of a conversion |
| flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input changes only in step with `clk` and that `trig_in` is already synchronised. The edge detector compares each line with its value one cycle earlier, and the properties about edges rely on that. They make no assumption about how often `conv_tick` arrives, or about write strobes that coincide with `done`, because the block must resolve those cases itself. The stimulus drives every input on the falling clock edge, holds `src_sel` steady around each trigger edge it creates, and includes the coincident clear-and-done case and a stalled conversion clock on purpose.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // conversion length in conversion-clock ticks
  localparam int unsigned CONV_TICKS = 13;
  // number of trigger select codes
  localparam int unsigned NUM_SRC    = 8;
  // select code that means "completion event" (free-running)
  localparam int unsigned FREE_CODE  = 0;

  // origin of a start, used by the top for its own checks
  typedef enum logic [1:0] {
    ORG_NONE = 2'd0,
    ORG_SW   = 2'd1,
    ORG_TRIG = 2'd2,
    ORG_FREE = 2'd3
  } start_origin_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               edge_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise_vec;

  // previous level per line; reset high so a line already high is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= trig_in;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_rise
      assign rise_vec[gi] = trig_in[gi] & ~prev_q[gi];
    end
  endgenerate

  assign edge_o = rise_vec[sel];

  localparam logic [NUM_SRC-1:0] ONE_HOT0 = NUM_SRC'(1);

  // an edge needs the selected line high now and low one cycle ago
  p_edge_is_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (trig_in[sel] && (($past(trig_in) & (ONE_HOT0 << sel)) == '0)));

  // a line held high gives no second edge
  p_held_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in[sel] && $stable(trig_in) && $stable(sel)) |=> !edge_o || !$stable(trig_in));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_TICKS = 13,
  parameter int unsigned CNT_W      = $clog2(CONV_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en && busy_q && tick_i && (cnt_q == LAST);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_o);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_i) |=> busy_o);

  p_done_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy_o && !tick_i && !start_i) |=> (busy_o && $stable(cnt_q)));

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/adc_done_flag.sv
module adc_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (done_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> flag_o);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done_i) |=> !flag_o);

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !clr_i) |=> (flag_o == $past(flag_o)));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i ##1 irq_en_i) |-> irq_o);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
  parameter int unsigned NUM_SRC    = adc_trig_pkg::NUM_SRC,
  parameter int unsigned CONV_TICKS = adc_trig_pkg::CONV_TICKS,
  parameter int unsigned FREE_CODE  = adc_trig_pkg::FREE_CODE,
  parameter int unsigned SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               auto_en,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic               start_wr,
  input  logic               flag_clr_wr,
  input  logic               irq_en,
  input  logic               conv_tick,
  output logic               start_pulse,
  output logic               busy,
  output logic               done,
  output logic               flag,
  output logic               irq
);
  import adc_trig_pkg::*;

  localparam int unsigned CNT_W = $clog2(CONV_TICKS);

  logic          sel_edge;
  logic          free_mode;
  logic          trig_req;
  logic          launch_idle;
  logic          launch_free;
  start_origin_e origin;

  adc_trig_edge #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_in(trig_in),
    .sel    (src_sel),
    .edge_o (sel_edge)
  );

  // start arbitration: idle launches from software or trigger edge,
  // plus back-to-back restart on completion in free-running mode
  assign free_mode   = auto_en && (src_sel == SEL_W'(FREE_CODE));
  assign trig_req    = auto_en && !free_mode && sel_edge;
  assign launch_idle = en && !busy && (start_wr || trig_req);
  assign launch_free = en && done && free_mode;
  assign start_pulse = launch_idle || launch_free;

  always_comb begin
    origin = ORG_NONE;
    if (launch_free)            origin = ORG_FREE;
    else if (launch_idle) begin
      if (start_wr)             origin = ORG_SW;
      else                      origin = ORG_TRIG;
    end
  end

  adc_conv_timer #(.CONV_TICKS(CONV_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .start_i(start_pulse),
    .tick_i (conv_tick),
    .busy_o (busy),
    .done_o (done)
  );

  adc_done_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .clr_i   (flag_clr_wr),
    .irq_en_i(irq_en),
    .flag_o  (flag),
    .irq_o   (irq)
  );

  p_no_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && busy) |-> (done && origin == ORG_FREE));

  p_free_keep_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && auto_en && src_sel == SEL_W'(FREE_CODE)) |=> busy);

  p_off_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !start_pulse);

  p_trig_needs_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (origin == ORG_TRIG) |-> (auto_en && src_sel != SEL_W'(FREE_CODE)));

  p_sw_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start_wr) |-> !start_pulse);
endmodule

// File: tb/adc_trig_ctrl_tb_top.sv
module adc_trig_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, auto_en, start_wr, flag_clr_wr, irq_en, conv_tick;
  logic [2:0] src_sel;
  logic [7:0] trig_in;
  logic       start_pulse, busy, done, flag, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_trig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .auto_en(auto_en), .src_sel(src_sel),
    .trig_in(trig_in), .start_wr(start_wr), .flag_clr_wr(flag_clr_wr),
    .irq_en(irq_en), .conv_tick(conv_tick), .start_pulse(start_pulse),
    .busy(busy), .done(done), .flag(flag), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // strobe start_wr on a falling edge; sample start_pulse 1 ns later
  task automatic strobe_start(output int sp);
    @(negedge clk);
    start_wr = 1'b1;
    #1 sp = start_pulse;
  endtask

  // count falling edges until done is seen (start_wr released on the first)
  task automatic wait_done(output int n);
    n = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      start_wr = 1'b0;
      #1;
      if (done) begin n = k; break; end
    end
  endtask

  task automatic clear_flag;
    @(negedge clk);
    flag_clr_wr = 1'b1;
    @(negedge clk);
    flag_clr_wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "flag", flag, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "start_pulse", start_pulse, 0);
  endtask

  task automatic t_sw_start;
    int sp, n;
    auto_en = 0; irq_en = 0;
    strobe_start(sp);
    chk("R2", "start_pulse on write", sp, 1);
    wait_done(n);
    chk("R3", "done after 13 ticks", n, 13);
    chk("R3", "busy during done cycle", busy, 1);
    @(negedge clk); #1;
    chk("R3", "busy after done", busy, 0);
    chk("R7", "flag set with irq disabled", flag, 1);
    chk("R8", "irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R8", "irq when enabled", irq, 1);
    clear_flag(); #1;
    chk("R7", "flag cleared", flag, 0);
    chk("R8", "irq after clear", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_busy_ignore;
    int sp, n, sp2;
    sp2 = 0; n = -1;
    strobe_start(sp);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      start_wr = (k == 5);
      #1;
      if (k == 5) sp2 = start_pulse;
      if (done) begin n = k; break; end
    end
    start_wr = 0;
    chk("R10", "start_pulse for write while busy", sp2, 0);
    chk("R10", "done not delayed", n, 13);
    @(negedge clk); #1;
    chk("R10", "no restart", busy, 0);
    clear_flag();
  endtask

  task automatic t_auto_trig;
    int n;
    auto_en = 1; src_sel = 3;
    @(negedge clk); trig_in[5] = 1; #1;
    chk("R4", "unselected line edge", start_pulse, 0);
    @(negedge clk); #1;
    chk("R4", "idle after unselected edge", busy, 0);
    trig_in[3] = 1; #1;
    chk("R4", "selected line edge", start_pulse, 1);
    wait_done(n);
    chk("R4", "triggered conversion length", n, 13);
    idle_cycles(5); #1;
    chk("R5", "held line starts once", busy, 0);
    @(negedge clk); trig_in[3] = 0;
    @(negedge clk); trig_in[3] = 1; #1;
    chk("R5", "new edge after low", start_pulse, 1);
    wait_done(n);
    @(negedge clk); trig_in[3] = 0; auto_en = 0;
    @(negedge clk); trig_in[3] = 1; #1;
    chk("R4", "edge with auto off", start_pulse, 0);
    @(negedge clk); trig_in = '0; trig_in[5] = 0;
    clear_flag();
  endtask

  task automatic t_edge_busy;
    int n, sp6;
    n = -1; sp6 = 0;
    auto_en = 1; src_sel = 2;
    @(negedge clk); trig_in[2] = 1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 4) trig_in[2] = 0;
      if (k == 6) trig_in[2] = 1;
      #1;
      if (k == 6) sp6 = start_pulse;
      if (done) begin n = k; break; end
    end
    chk("R5", "edge during busy no start", sp6, 0);
    chk("R5", "first conversion length", n, 13);
    idle_cycles(15); #1;
    chk("R5", "dropped edge not replayed", busy, 0);
    clear_flag();
  endtask

  task automatic t_sw_with_auto;
    int sp, n;
    auto_en = 1; src_sel = 2;  // trig_in[2] still high, no edge
    strobe_start(sp);
    chk("R11", "write starts with auto on", sp, 1);
    wait_done(n);
    chk("R11", "conversion length", n, 13);
    @(negedge clk); trig_in = '0; auto_en = 0;
    clear_flag();
  endtask

  task automatic t_free_run;
    int sp, n, sp_done;
    n = -1; sp_done = 0;
    auto_en = 1; src_sel = 0;
    @(negedge clk); trig_in[0] = 1; #1;
    chk("R6", "line 0 has no effect", start_pulse, 0);
    idle_cycles(20); #1;
    chk("R6", "no start before write", busy, 0);
    strobe_start(sp);
    chk("R6", "first start by write", sp, 1);
    wait_done(n);
    chk("R6", "first done", n, 13);
    chk("R6", "restart with done", start_pulse, 1);
    @(negedge clk); #1;
    chk("R6", "stays busy", busy, 1);
    n = -1;
    for (int k = 15; k <= 60; k++) begin
      @(negedge clk);
      if (k == 27) auto_en = 0;
      #1;
      if (done && k == 26) sp_done = start_pulse;
      if (done && k > 26) begin n = k; break; end
    end
    chk("R6", "second restart with flag uncleared", sp_done, 1);
    chk("R6", "third done", n, 39);
    @(negedge clk); #1;
    chk("R6", "stops after auto off", busy, 0);
    trig_in = '0;
    clear_flag();
  endtask

  task automatic t_collision;
    int sp, n;
    auto_en = 0;
    strobe_start(sp);
    wait_done(n);
    chk("R7", "done timing", n, 13);
    flag_clr_wr = 1;
    @(negedge clk); flag_clr_wr = 0; #1;
    chk("R7", "set wins over clear", flag, 1);
    clear_flag(); #1;
    chk("R7", "later clear works", flag, 0);
  endtask

  task automatic t_abort;
    int sp, seen;
    seen = 0;
    strobe_start(sp);
    for (int k = 1; k <= 5; k++) begin @(negedge clk); start_wr = 0; end
    en = 0;
    @(negedge clk); #1;
    chk("R9", "busy after disable", busy, 0);
    start_wr = 1; #1;
    chk("R9", "no start while disabled", start_pulse, 0);
    @(negedge clk); start_wr = 0; #1;
    chk("R9", "still idle", busy, 0);
    en = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (done) seen = 1;
    end
    chk("R9", "aborted conversion never done", seen, 0);
    chk("R9", "flag not set", flag, 0);
  endtask

  task automatic t_tick_gate;
    int sp, seen, n;
    seen = 0;
    conv_tick = 0;
    strobe_start(sp);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); start_wr = 0; #1;
      if (done) seen = 1;
    end
    chk("R3", "stalled ticks no done", seen, 0);
    chk("R3", "stalled ticks stay busy", busy, 1);
    conv_tick = 1;
    wait_done(n);
    chk("R3", "done after 12 more ticks", n, 12);
    clear_flag();
  endtask

  initial begin
    rst_n = 0; en = 1; auto_en = 0; src_sel = 0; trig_in = '0;
    start_wr = 0; flag_clr_wr = 0; irq_en = 0; conv_tick = 1;
    idle_cycles(3);
    rst_n = 1;
    t_reset();
    t_sw_start();
    t_busy_ignore();
    t_auto_trig();
    t_edge_busy();
    t_sw_with_auto();
    t_free_run();
    t_collision();
    t_abort();
    t_tick_gate();
    idle_cycles(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule